// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave-side protocol engine of a small two-wire serial memory. It oversamples the clock and data lines with a fast system clock, recognises start and stop conditions, and decodes the first byte of every transfer as a device select word. The select word carries a fixed type code, up to three chip-select bits compared against strap pins, and a read/write flag. A density parameter decides how many of the three select bits are compared against the straps and how many are reused as high-order page bits of the array address.

A byte write is a select word with the write flag, a word address and one data byte, each acknowledged by pulling the data line low, then a stop. The stop starts a modeled internal programming period of a parameterised number of system clocks. The array is updated at the end of that period, and the block ignores the bus completely until then. A single-byte read uses the usual random-read form: select word with write flag, word address, repeated start, select word with read flag. The slave then shifts out the byte at the selected page and the last received word address.

The open-drain pad is reduced to one output, a drive-low enable. The data line seen by the block is the wired-AND of the master and this enable.

Top module: `serial_mem_slave`

## Requirements
- R1: A select word is accepted only if its four first-sent bits (bits 7..4) are 1,0,1,0. Any other code gets no acknowledge.
- R2: Bits 3..1 of the select word are split by PAGE_BITS (0 to 3). The lowest PAGE_BITS of them are page bits and are not compared. The remaining upper bits must equal `sel_pins_i` at the same positions (bit 3 against pin 2, bit 2 against pin 1, bit 1 against pin 0). The array address is {page bits, 8-bit word address}.
- R3: For a matching select word, a word address and a data byte, the slave drives `sda_pull_o` high only while SCL is low. It holds it through the whole ninth clock and releases it after the ninth falling edge.
- R4: After a select word that fails R1 or R2, the slave does not acknowledge anything until the next start condition.
- R5: A byte write is committed only by a stop after the acknowledged data byte, and only after TWR_CYC system clocks. A repeated start in place of that stop leaves the array unchanged.
- R6: From that stop until the programming period ends, all bus activity is ignored, and no select word is acknowledged.
- R7: A start or stop that arrives before all eight data bits are received aborts the transfer without writing.
- R8: A select word with bit 0 = 1 (read) is acknowledged and followed by the byte at {page bits of that word, last received word address}, sent MSB first. Each bit is changed only while SCL is low, and the line is released for the master's ninth bit.
- R9: After reset the drive-low enable is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus) |
| sel_pins_i | input | 3 | Hardwired chip-select straps |
| sda_pull_o | output | 1 | Drive-low enable for the data pad |

## Verification
Two functions meet in one cycle when the end of a byte write collides with new bus traffic. A master that starts a fresh transfer right after the stop hits a programming period that must swallow it. A repeated start where the stop belongs must abandon the write rather than commit it. The bench provokes the first by sending a select word immediately after a write and expecting no acknowledge. It provokes the second by issuing a repeated start after the acknowledged data byte and expecting the old byte back. Reads after the programming period judge both against a bench memory model.

// File: rtl/sms_pkg.sv
package sms_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_WAIT_STOP,
    ST_RDATA,
    ST_RD_ACK,
    ST_BUSY
  } sms_state_e;

  localparam logic [3:0] SMS_TYPE_CODE = 4'b1010;
  localparam int unsigned SMS_WORD_BITS = 8;

endpackage

// File: rtl/sms_line_sync.sv
module sms_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  localparam int unsigned PW = SYNC_STAGES + 1;

  logic [PW-1:0] scl_pipe_q, sda_pipe_q;
  logic          scl_now, scl_prev, sda_now, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[PW-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[PW-2:0], sda_i};
    end
  end

  assign scl_now  = scl_pipe_q[PW-2];
  assign scl_prev = scl_pipe_q[PW-1];
  assign sda_now  = sda_pipe_q[PW-2];
  assign sda_prev = sda_pipe_q[PW-1];

  assign scl_lvl_o  = scl_now;
  assign sda_lvl_o  = sda_now;
  assign scl_rise_o = scl_now & ~scl_prev;
  assign scl_fall_o = ~scl_now & scl_prev;
  assign start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;

  AST_ONE_LINE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o})); // R7

endmodule

// File: rtl/sms_addr_match.sv
module sms_addr_match
  import sms_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 1
) (
  input  logic [7:0] dev_word_i,
  input  logic [2:0] sel_pins_i,
  output logic       hit_o,
  output logic [2:0] page_o,
  output logic       rd_o
);

  localparam int unsigned SEL_BITS = 3 - PAGE_BITS;
  localparam logic [2:0]  PMASK    = 3'((1 << PAGE_BITS) - 1);

  logic pins_ok;

  generate
    if (SEL_BITS == 0) begin : g_no_pins
      assign pins_ok = 1'b1;
    end else begin : g_pins
      assign pins_ok = (dev_word_i[3:PAGE_BITS+1] == sel_pins_i[2:PAGE_BITS]);
    end
  endgenerate

  assign hit_o  = (dev_word_i[7:4] == SMS_TYPE_CODE) && pins_ok;
  assign page_o = dev_word_i[3:1] & PMASK;
  assign rd_o   = dev_word_i[0];

endmodule

// File: rtl/sms_byte_array.sv
module sms_byte_array #(
  parameter int unsigned AW = 9
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[addr_i];

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import sms_pkg::*;
#(
  parameter int unsigned PAGE_BITS   = 1,
  parameter int unsigned TWR_CYC     = 1500,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] sel_pins_i,
  output logic       sda_pull_o
);

  localparam int unsigned AW = SMS_WORD_BITS + PAGE_BITS;
  localparam int unsigned CW = $clog2(TWR_CYC + 1);
  localparam logic [CW-1:0] TWR_LAST = CW'(TWR_CYC - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // line conditioning
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

  sms_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_lvl_o  (scl_lvl),
    .sda_lvl_o  (sda_lvl),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  // state
  sms_state_e    state_q, state_d;
  logic [3:0]    cnt_q, cnt_d;
  logic [7:0]    sh_q, sh_d;
  logic          pull_q, pull_d;
  logic [2:0]    page_q, page_d;
  logic [7:0]    word_q, word_d;
  logic [7:0]    data_q, data_d;
  logic [CW-1:0] twr_q, twr_d;

  // select word decode
  logic       hit, rd_req;
  logic [2:0] hit_page;

  sms_addr_match #(.PAGE_BITS(PAGE_BITS)) u_match (
    .dev_word_i (sh_q),
    .sel_pins_i (sel_pins_i),
    .hit_o      (hit),
    .page_o     (hit_page),
    .rd_o       (rd_req)
  );

  // array
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata;

  assign mem_addr = AW'({page_q, word_q});

  sms_byte_array #(.AW(AW)) u_array (
    .clk     (clk),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (data_q),
    .rdata_o (mem_rdata)
  );

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    pull_d  = pull_q;
    page_d  = page_q;
    word_d  = word_q;
    data_d  = data_q;
    twr_d   = twr_q;
    mem_we  = 1'b0;

    if (state_q == ST_BUSY) begin
      if (twr_q == TWR_LAST) begin
        mem_we  = 1'b1;
        twr_d   = '0;
        state_d = ST_IDLE;
      end else begin
        twr_d = twr_q + 1'b1;
      end
    end else if (start_ev) begin
      state_d = ST_DEV;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (stop_ev) begin
      pull_d = 1'b0;
      if (state_q == ST_WAIT_STOP) begin
        state_d = ST_BUSY;
        twr_d   = '0;
      end else begin
        state_d = ST_IDLE;
      end
    end else begin
      unique case (state_q)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sh_d  = {sh_q[6:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end
          if (scl_fall && cnt_q == 4'd8) begin
            if (state_q == ST_DEV) begin
              if (hit) begin
                pull_d  = 1'b1;
                page_d  = hit_page;
                state_d = ST_DEV_ACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_WADDR) begin
              word_d  = sh_q;
              pull_d  = 1'b1;
              state_d = ST_WADDR_ACK;
            end else begin
              data_d  = sh_q;
              pull_d  = 1'b1;
              state_d = ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rd_req) begin
              sh_d    = mem_rdata;
              pull_d  = ~mem_rdata[7];
              state_d = ST_RDATA;
            end else begin
              pull_d  = 1'b0;
              state_d = ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            cnt_d   = '0;
            state_d = ST_WDATA;
          end
        end
        ST_WDATA_ACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            state_d = ST_WAIT_STOP;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              pull_d  = 1'b0;
              state_d = ST_RD_ACK;
            end else begin
              pull_d = ~sh_q[6];
              sh_d   = {sh_q[6:0], 1'b0};
              cnt_d  = cnt_q + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_fall) state_d = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      pull_q  <= 1'b0;
      page_q  <= '0;
      word_q  <= '0;
      data_q  <= '0;
      twr_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      pull_q  <= pull_d;
      page_q  <= page_d;
      word_q  <= word_d;
      data_q  <= data_d;
      twr_q   <= twr_d;
    end
  end

  assign sda_pull_o = pull_q;

  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q == ST_BUSY) |-> !pull_q); // R6

  AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(pull_q) |-> !scl_lvl); // R3

  AST_NO_ACK_ON_MISS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q == ST_DEV && scl_fall && cnt_q == 4'd8 && !hit) |=> (!pull_q && state_q == ST_IDLE)); // R4

  AST_STOP_ARMS_TWR: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q == ST_WAIT_STOP && stop_ev && !start_ev) |=> (state_q == ST_BUSY && twr_q == '0)); // R5

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (start_ev && state_q != ST_BUSY) |=> (state_q == ST_DEV && !pull_q)); // R7

endmodule

// File: tb/serial_mem_slave_bench.sv
`timescale 1ns/1ps
module serial_mem_slave_bench;

  localparam int unsigned PB   = 1;
  localparam int unsigned TWR  = 1500;
  localparam logic [2:0]  SEL  = 3'b101;
  localparam int          Q    = 10;
  localparam int          NMEM = 1 << (8 + PB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull;
  logic sda_line;

  int checks = 0;
  int failures = 0;

  logic [7:0] mdl   [NMEM];
  bit         known [NMEM];
  int         wlist [$];

  always #2 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull;

  serial_mem_slave #(.PAGE_BITS(PB), .TWR_CYC(TWR), .SYNC_STAGES(2)) u_serial_mem_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sel_pins_i (SEL),
    .sda_pull_o (sda_pull)
  );

  // ---- expectation functions
  function automatic logic [2:0] f_field(input logic [2:0] page);
    logic [2:0] fld;
    for (int k = 0; k < 3; k++) fld[k] = (k < PB) ? page[k] : SEL[k];
    return fld;
  endfunction

  function automatic logic f_expect_ack(input logic [7:0] da);
    logic ok;
    ok = (da[7] == 1'b1) && (da[6] == 1'b0) && (da[5] == 1'b1) && (da[4] == 1'b0);
    for (int k = 0; k < 3; k++)
      if (k >= PB && da[k+1] != SEL[k]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [7:0] f_da(input logic [2:0] page, input logic rw);
    return {4'b1010, f_field(page), rw};
  endfunction

  // ---- bench plumbing
  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wq(Q);
      m_scl = 1'b1; wq(2 * Q);
      m_scl = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit chk_rel, output bit ack);
    send_bits(b, 8);
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    ack = (sda_line == 1'b0);
    wq(Q);
    m_scl = 1'b0; wq(Q);
    if (chk_rel) chk(sda_pull == 1'b0, "R3 release after ninth clock", sda_pull, 0);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(Q);
      b[i] = sda_line;
      wq(Q);
      m_scl = 1'b0; wq(Q);
    end
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1;
    wq(Q);
    chk(sda_pull == 1'b0, "R8 line free for master ack bit", sda_pull, 0);
    wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic do_write(input logic [2:0] page, input logic [7:0] word, input logic [7:0] data);
    bit a;
    int idx;
    bus_start();
    send_byte(f_da(page, 1'b0), 1'b1, a); chk(a, "R3 ack select word (write)", a, 1);
    send_byte(word, 1'b1, a);             chk(a, "R3 ack word address", a, 1);
    send_byte(data, 1'b1, a);             chk(a, "R3 ack data byte", a, 1);
    bus_stop();
    idx = int'(page) * 256 + int'(word);
    mdl[idx] = data;
    known[idx] = 1'b1;
  endtask

  task automatic do_read(input logic [2:0] page, input logic [7:0] word, input logic [7:0] exp, input string tag);
    bit a;
    logic [7:0] got;
    bus_start();
    send_byte(f_da(page, 1'b0), 1'b1, a); chk(a, "R8 ack select word before read", a, 1);
    send_byte(word, 1'b1, a);             chk(a, "R8 ack word address before read", a, 1);
    bus_start();
    send_byte(f_da(page, 1'b1), 1'b0, a); chk(a, "R8 ack read select word", a, 1);
    recv_byte(got);
    bus_stop();
    chk(got == exp, tag, got, exp);
  endtask

  task automatic wait_twr();
    wq(TWR + 200);
  endtask

  // ---- watchdog
  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---- main sequence
  initial begin
    bit a;
    logic [7:0] da;
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED);

    wq(20);
    rst_n = 1'b1;
    wq(10);
    chk(sda_pull == 1'b0, "R9 drive released after reset", sda_pull, 0);

    // directed byte write, immediate retry during programming, read back
    do_write(3'd0, 8'h3C, 8'hA5);
    bus_start();
    send_byte(f_da(3'd0, 1'b0), 1'b0, a);
    chk(!a, "R6 no ack during programming period", a, 0);
    send_byte(8'h3C, 1'b0, a);
    chk(!a, "R6 bus ignored during programming period", a, 0);
    bus_stop();
    wait_twr();
    do_read(3'd0, 8'h3C, 8'hA5, "R5 byte committed after stop and TWR");

    // page bits select another location with the same word address
    do_write(3'd1, 8'h3C, 8'h5A);
    wait_twr();
    do_read(3'd1, 8'h3C, 8'h5A, "R2 page bit 1 location");
    do_read(3'd0, 8'h3C, 8'hA5, "R2 page bit 0 location kept");

    // wrong type code
    bus_start();
    da = {4'b1011, f_field(3'd0), 1'b0};
    send_byte(da, 1'b1, a);
    chk(a == f_expect_ack(da), "R1 wrong type code not acked", a, 0);
    bus_stop();

    // wrong strap bit, then a valid-looking byte without a new start
    bus_start();
    da = {4'b1010, f_field(3'd0) ^ 3'b100, 1'b0};
    send_byte(da, 1'b1, a);
    chk(a == f_expect_ack(da), "R2 strap mismatch not acked", a, 0);
    send_byte(f_da(3'd0, 1'b0), 1'b1, a);
    chk(!a, "R4 standby until next start", a, 0);
    bus_stop();

    // stop inside the data byte
    bus_start();
    send_byte(f_da(3'd0, 1'b0), 1'b0, a);
    send_byte(8'h3C, 1'b0, a);
    send_bits(8'h11, 4);
    bus_stop();
    wait_twr();
    do_read(3'd0, 8'h3C, 8'hA5, "R7 stop mid data byte aborts");

    // start inside the data byte
    bus_start();
    send_byte(f_da(3'd0, 1'b0), 1'b0, a);
    send_byte(8'h3C, 1'b0, a);
    send_bits(8'h22, 5);
    bus_start();
    bus_stop();
    wait_twr();
    do_read(3'd0, 8'h3C, 8'hA5, "R7 start mid data byte aborts");

    // complete data byte followed by repeated start instead of stop
    bus_start();
    send_byte(f_da(3'd0, 1'b0), 1'b0, a);
    send_byte(8'h3C, 1'b0, a);
    send_byte(8'hFF, 1'b0, a);
    chk(a, "R3 ack data byte before repeated start", a, 1);
    bus_start();
    send_byte(f_da(3'd0, 1'b1), 1'b0, a);
    chk(a, "R6 not busy when no stop followed data", a, 1);
    begin
      logic [7:0] got;
      recv_byte(got);
      bus_stop();
      chk(got == 8'hA5, "R5 repeated start does not commit", got, 8'hA5);
    end

    // constrained random traffic
    for (int it = 0; it < 14; it++) begin
      logic [2:0] pg;
      logic [7:0] wd, dt;
      int pick;
      pg = 3'($urandom % (1 << PB));
      wd = 8'($urandom);
      dt = 8'($urandom);
      do_write(pg, wd, dt);
      wlist.push_back(int'(pg) * 256 + int'(wd));
      wait_twr();

      pick = wlist[$urandom % wlist.size()];
      do_read(3'(pick / 256), 8'(pick % 256), mdl[pick], "R8 random read matches model");

      da = {(($urandom % 4) == 0) ? 4'($urandom) : 4'b1010, 3'($urandom), 1'b0};
      bus_start();
      send_byte(da, 1'b0, a);
      chk(a == f_expect_ack(da), "R1 R2 random select word decode", a, f_expect_ack(da));
      bus_stop();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule